// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block splits the system clock into a repeating run of four phase strobes. One full run of the four phases is one instruction cycle. Around that cycle it runs a two-stage pipeline. The program counter drives the fetch address. The instruction word fetched in one instruction cycle is held for the execute stage throughout the next cycle. As a result, fetch of address N overlaps execution of address N-1, and straight-line code completes one instruction per instruction cycle.

A downstream execute stage may request a change of flow. It raises a jump request together with a target address while a valid instruction is executing. The counter loads the target at the next cycle boundary. The word that was fetched behind the jump is dropped and shows up as one empty execute cycle. A jump therefore costs two instruction cycles.

The block also drives a sync output for external logic. This output is high during the first phase only, so it runs at one quarter of the clock rate with a 1:3 high/low duty.

The fetch word and the executed word have no back-pressure. There is no ready signal, and the pipeline advances every instruction cycle. The valid flag only qualifies the execute word. Jump inputs are plain control pins.

Top module: `quad_phase_sequencer`

## Requirements
- R1: In every clock period after reset, exactly one bit of `phase_o` is high. Bit 0 is T1, bit 1 is T2, bit 2 is T3 and bit 3 is T4.
- R2: The phases step in the fixed order T1, T2, T3, T4, then back to T1, advancing by one on each rising clock edge.
- R3: `t1_sync_o` is high exactly while T1 is active. It is therefore high for one clock and low for three.
- R4: While reset is asserted, the block shows phase T1, `fetch_addr_o` = 0, `exec_valid_o` = 0 and `t1_sync_o` = 1. The first instruction cycle after reset fetches address 0 and has no valid execute word.
- R5: `fetch_addr_o` holds steady for a whole instruction cycle. It changes only at the edge that ends T4. Without a jump it increases by one.
- R6: `fetch_word_i` is sampled at the edge that ends T4. It appears on `exec_word_o` with `exec_valid_o` = 1 for the whole of the next instruction cycle, unless that word was dropped.
- R7: Suppose `jump_req_i` is high at the edge that ends T4 while `exec_valid_o` = 1. Then `fetch_addr_o` equals `jump_addr_i` in the following instruction cycle.
- R8: After an accepted jump, `exec_valid_o` is 0 for exactly one instruction cycle. The target's word executes, with valid set, in the cycle after that.
- R9: `jump_req_i` has no effect while `exec_valid_o` = 0, and none when it is low at the edge that ends T4, even if it was high in T1 to T3.
- R10: The program counter wraps from all ones to 0 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word_i | input | INSTR_W | Word read from program memory at `fetch_addr_o` |
| jump_req_i | input | 1 | Execute stage requests a program counter load |
| jump_addr_i | input | ADDR_W | Target address for the jump |
| phase_o | output | NUM_PH | One-hot phase strobes, bit 0 is T1 |
| fetch_addr_o | output | ADDR_W | Current program counter, used as the fetch address |
| exec_word_o | output | INSTR_W | Word being executed this instruction cycle |
| exec_valid_o | output | 1 | `exec_word_o` holds a real instruction |
| t1_sync_o | output | 1 | Sync output, high during T1 |

## Verification
On every clock, the embedded assertions check four things: the one-hot strobes and their fixed rotation, the sync output tracking T1, the counter staying still inside a cycle and stepping or loading only at the T4 boundary, and the execute register refilling or emptying only at that boundary. Only the bench's scenarios can show the end-to-end cost of a jump. The scenarios cover the exact address sequence seen by the execute stage, requests that are dropped during a bubble or right after reset, back-to-back jumps, counter wrap, and reset in the middle of a cycle. The bench compares these against a program memory whose words encode their own address.

// File: rtl/qps_pkg.sv
`timescale 1ns/1ps
package qps_pkg;
  // Phase index of the strobe that starts every instruction cycle.
  localparam int unsigned PH_FIRST = 0;

  // Next value of a wrapping phase index, given the last legal index.
  function automatic logic [7:0] ph_next(input logic [7:0] cur, input logic [7:0] last);
    return (cur == last) ? 8'd0 : cur + 8'd1;
  endfunction
endpackage

// File: rtl/qps_phase_ring.sv
`timescale 1ns/1ps
module qps_phase_ring #(
  parameter int unsigned NUM_PH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [NUM_PH-1:0] phase_o,
  output logic              cyc_end_o,
  output logic              sync_o
);
  import qps_pkg::*;
  localparam int unsigned PH_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;
  localparam logic [7:0] LAST = 8'(NUM_PH - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic            sync_q;

  always_comb ph_d = PH_W'(ph_next(8'(ph_q), LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sync_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      sync_q <= (ph_d == PH_W'(PH_FIRST));
    end
  end

  for (genvar i = 0; i < NUM_PH; i++) begin : g_strobe
    assign phase_o[i] = (ph_q == PH_W'(i));
  end

  assign cyc_end_o = (ph_q == PH_W'(NUM_PH - 1));
  assign sync_o    = sync_q;

  // R1: exactly one strobe active
  assert_onehot_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1);

  // R2: fixed rotation of strobes
  for (genvar i = 0; i < NUM_PH; i++) begin : g_order_chk
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o[i] |=> phase_o[(i + 1) % NUM_PH]);
  end

  // R3: separate sync flop follows first strobe
  assert_sync_tracks_t1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o == phase_o[0]);
  assert_sync_one_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);
endmodule

// File: rtl/qps_pc_unit.sv
`timescale 1ns/1ps
module qps_pc_unit #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_end_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (cyc_end_i) begin
      pc_q <= redirect_i ? target_i : pc_q + ADDR_W'(1);
    end
  end

  assign pc_o = pc_q;

  // R5: counter frozen inside an instruction cycle
  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end_i |=> $stable(pc_o));
  // R5: sequential step at the boundary
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end_i && !redirect_i && pc_o != '1) |=> pc_o == $past(pc_o) + ADDR_W'(1));
  // R10: wrap to zero
  assert_pc_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end_i && !redirect_i && pc_o == '1) |=> pc_o == '0);
  // R7: target load
  assert_pc_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end_i && redirect_i) |=> pc_o == $past(target_i));
endmodule

// File: rtl/qps_exec_stage.sv
`timescale 1ns/1ps
module qps_exec_stage #(
  parameter int unsigned INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_end_i,
  input  logic               squash_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [INSTR_W-1:0] word_o,
  output logic               valid_o
);
  logic [INSTR_W-1:0] word_q;
  logic               valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (cyc_end_i) begin
      word_q  <= word_i;
      valid_q <= !squash_i;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R6: execute register steady within a cycle
  assert_exec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end_i |=> ($stable(word_o) && $stable(valid_o)));
  // R6: fetched word moves to execute
  assert_exec_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end_i && !squash_i) |=> (valid_o && word_o == $past(word_i)));
  // R8: dropped slot after a jump
  assert_exec_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end_i && squash_i) |=> !valid_o);
endmodule

// File: rtl/quad_phase_sequencer.sv
`timescale 1ns/1ps
module quad_phase_sequencer #(
  parameter int unsigned NUM_PH  = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] fetch_word_i,
  input  logic               jump_req_i,
  input  logic [ADDR_W-1:0]  jump_addr_i,
  output logic [NUM_PH-1:0]  phase_o,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic [INSTR_W-1:0] exec_word_o,
  output logic               exec_valid_o,
  output logic               t1_sync_o
);
  logic cyc_end;
  logic redirect;

  // A jump counts only from a real instruction (R9).
  assign redirect = jump_req_i && exec_valid_o;

  qps_phase_ring #(.NUM_PH(NUM_PH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_o   (phase_o),
    .cyc_end_o (cyc_end),
    .sync_o    (t1_sync_o)
  );

  qps_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_end_i  (cyc_end),
    .redirect_i (redirect),
    .target_i   (jump_addr_i),
    .pc_o       (fetch_addr_o)
  );

  qps_exec_stage #(.INSTR_W(INSTR_W)) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_end_i (cyc_end),
    .squash_i  (redirect),
    .word_i    (fetch_word_i),
    .word_o    (exec_word_o),
    .valid_o   (exec_valid_o)
  );

  // R9: an idle execute stage never moves the counter off its step
  assert_ignore_idle_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[NUM_PH-1] && !exec_valid_o && fetch_addr_o != '1) |=>
      fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));
endmodule

// File: tb/sim_quad_phase_sequencer.sv
`timescale 1ns/1ps
module sim_quad_phase_sequencer;
  localparam int NPH = 4;
  localparam int AW  = 12;
  localparam int IW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] fetch_word;
  logic          jreq = 1'b0;
  logic [AW-1:0] jaddr = '0;
  logic [NPH-1:0] phase;
  logic [AW-1:0] faddr;
  logic [IW-1:0] eword;
  logic          evalid;
  logic          sync;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Program memory model: each word carries its own address.
  assign fetch_word = {4'hC, faddr};

  quad_phase_sequencer #(.NUM_PH(NPH), .ADDR_W(AW), .INSTR_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_word_i(fetch_word), .jump_req_i(jreq),
    .jump_addr_i(jaddr), .phase_o(phase), .fetch_addr_o(faddr),
    .exec_word_o(eword), .exec_valid_o(evalid), .t1_sync_o(sync));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks one phase p of an instruction cycle.
  task automatic chk_phase(input int p, input logic [AW-1:0] ef, input logic ev, input logic [AW-1:0] ex);
    chk(phase == NPH'(1 << p), "R1/R2 phase strobe", 32'(phase), 32'(1 << p));
    chk(sync == (p == 0), "R3 sync duty", 32'(sync), 32'(p == 0));
    chk(faddr == ef, "R5/R7/R10 fetch address", 32'(faddr), 32'(ef));
    chk(evalid == ev, "R6/R8/R9 exec valid", 32'(evalid), 32'(ev));
    if (ev) chk(eword == {4'hC, ex}, "R6 exec word", 32'(eword), 32'({4'hC, ex}));
  endtask

  // {jump, target, expected fetch, expected exec addr, expected valid}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 12'h050, 12'h000, 12'h000, 1'b0},  // R4/R9 jump after reset ignored
    {1'b0, 12'h000, 12'h001, 12'h000, 1'b1},
    {1'b0, 12'h000, 12'h002, 12'h001, 1'b1},
    {1'b1, 12'h100, 12'h003, 12'h002, 1'b1},  // R7 jump
    {1'b1, 12'h300, 12'h100, 12'h000, 1'b0},  // R8 bubble, R9 ignored
    {1'b0, 12'h000, 12'h101, 12'h100, 1'b1},
    {1'b1, 12'hFFF, 12'h102, 12'h101, 1'b1},
    {1'b1, 12'h040, 12'hFFF, 12'h000, 1'b0},  // R9 ignored in bubble
    {1'b0, 12'h000, 12'h000, 12'hFFF, 1'b1},  // R10 wrap
    {1'b1, 12'h010, 12'h001, 12'h000, 1'b1},
    {1'b0, 12'h000, 12'h010, 12'h000, 1'b0},
    {1'b1, 12'h020, 12'h011, 12'h010, 1'b1},  // jump right after bubble
    {1'b0, 12'h000, 12'h020, 12'h000, 1'b0},
    {1'b0, 12'h000, 12'h021, 12'h020, 1'b1}
  };

  initial begin : watchdog
    #(20 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R4: state under reset
    chk(phase == 4'b0001, "R4 reset phase", 32'(phase), 32'h1);
    chk(faddr == '0, "R4 reset pc", 32'(faddr), 32'h0);
    chk(evalid == 1'b0, "R4 reset valid", 32'(evalid), 32'h0);
    chk(sync == 1'b1, "R4 reset sync", 32'(sync), 32'h1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      for (int p = 0; p < NPH; p++) begin
        jreq  = VEC[k][37];
        jaddr = VEC[k][36:25];
        chk_phase(p, VEC[k][24:13], VEC[k][0], VEC[k][12:1]);
        @(negedge clk);
      end
    end

    // R9: request high in T1..T3 only, low at T4 -> no effect
    for (int p = 0; p < NPH; p++) begin
      jreq  = (p != NPH - 1);
      jaddr = 12'h300;
      chk_phase(p, 12'h022, 1'b1, 12'h021);
      @(negedge clk);
    end
    jreq = 1'b0;
    chk_phase(0, 12'h023, 1'b1, 12'h022);  // R9 sequential fetch kept
    @(negedge clk);

    // R4: reset in the middle of a cycle (now in T2)
    rst_n = 1'b0;
    #1;
    chk(phase == 4'b0001, "R4 mid-cycle reset phase", 32'(phase), 32'h1);
    chk(faddr == '0, "R4 mid-cycle reset pc", 32'(faddr), 32'h0);
    chk(evalid == 1'b0, "R4 mid-cycle reset valid", 32'(evalid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < NPH; p++) begin
      chk_phase(p, 12'h000, 1'b0, 12'h000);
      @(negedge clk);
    end
    chk_phase(0, 12'h001, 1'b1, 12'h000);  // R6 first word executes

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule